// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of a PCI device's configuration header. The bus interface logic drives single-cycle event pulses into it: parity errors, system-error assertion, master and target aborts. Each pulse is qualified by its own condition and then sets a sticky error flag. The qualifiers are the device's current role (initiator or target), whether the transaction was a special cycle, and the parity-error-response enable taken from the command register. Software reads the word through a combinational read port. It clears any flag by writing a 1 to that flag's bit position through a configuration write port with byte enables.

Some bits are fixed capability constants and are inserted when the word is read. The interrupt-status bit follows a live input. Each error flag is a small two-state machine, with states FLG_CLEAR and FLG_SET. The transition CLR_TO_SET fires on a qualified event. The transition SET_TO_CLR fires on a write-one clear when no event arrives in the same cycle. A flag in FLG_SET stays there through SET_HOLD, and the event wins any same-cycle collision, so no event is lost.

Top module: `pcists_status_reg`

## Requirements
- R1: After reset every error flag reads 0. With `irq_pending` low, `rd_data` reads 16'h00B0.
- R2: At all times, bits 10:9, bit 6 and bits 2:0 read 0, and bits 7, 5 and 4 read 1.
- R3: Bit 3 of `rd_data` equals `irq_pending` in the same cycle.
- R4: Bit 15 sets after a pulse on `ev_addr_parity` or `ev_data_parity`. The role and `perr_resp_en` have no effect on it.
- R5: Bit 14 sets after a pulse on `ev_serr`.
- R6: Bit 13 sets after a pulse on `ev_master_abort` while `is_master` is 1 and `ev_special_cycle` is 0. A special cycle leaves it unchanged.
- R7: Bit 12 sets after a pulse on `ev_ta_received` while `is_master` is 1. While `is_master` is 0 the pulse leaves it unchanged.
- R8: Bit 11 sets after a pulse on `ev_ta_signaled` while `is_master` is 0. While `is_master` is 1 the pulse leaves it unchanged.
- R9: Bit 8 sets after a pulse on `ev_data_parity` only when `is_master` and `perr_resp_en` are both 1.
- R10: A write with `wr_be[1]`=1 clears each of bits 15:11 and 8 whose `wr_data` bit is 1. Flags whose data bit is 0 are unchanged.
- R11: A write with `wr_be[1]`=0 changes no flag, whatever `wr_data` holds. Byte lane 1 covers bits 15:8.
- R12: When a set event and a write-one clear hit the same flag in the same cycle, the flag reads 1 afterwards.
- R13: A set flag stays at 1 until a write-one clear reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe for the status word |
| wr_data | input | 16 | Write data; a 1 clears the flag at that position |
| wr_be | input | 2 | Byte enables; bit 1 covers bits 15:8 |
| ev_addr_parity | input | 1 | Address parity error seen on the bus |
| ev_data_parity | input | 1 | Data parity error seen on the bus |
| ev_serr | input | 1 | System error signal asserted |
| ev_master_abort | input | 1 | Transaction ended by master-abort |
| ev_special_cycle | input | 1 | Current transaction is a special cycle |
| ev_ta_received | input | 1 | Transaction ended by a target-abort from the target |
| ev_ta_signaled | input | 1 | This device issued a target-abort |
| perr_resp_en | input | 1 | Parity-error-response enable from the command register |
| is_master | input | 1 | 1 when this device is the initiator |
| irq_pending | input | 1 | Live device interrupt status |
| rd_data | output | 16 | Current status word |

## Verification
The assertions check every cycle that the fixed bits hold their values and that bit 3 follows the interrupt input. They also check that a flag is not lost while no clear is written, that an event always wins over a same-cycle clear, and that writes with the high lane disabled, special cycles and wrong-role aborts leave the flags alone. Some behaviour only the bench's scenarios show. These are the exact reset value, the clearing of a chosen subset of flags while the others stay, and the full qualification table of master data parity across role and enable.

// File: rtl/pcists_pkg.sv
package pcists_pkg;

    localparam int STATUS_W  = 16;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = STATUS_W / LANE_W;
    localparam int NUM_FLAGS = 6;

    // Flag indices; the bit positions are fixed by the configuration header layout.
    localparam int FLG_DET_PARITY = 0;
    localparam int FLG_SIG_SERR   = 1;
    localparam int FLG_RCV_MABORT = 2;
    localparam int FLG_RCV_TABORT = 3;
    localparam int FLG_SIG_TABORT = 4;
    localparam int FLG_MST_PARITY = 5;

    localparam int BIT_IRQ = 3;

    // Bits that always read 1: fast back-to-back, 66 MHz, capabilities list.
    localparam logic [STATUS_W-1:0] FIXED_ONES = 16'h00B0;

    typedef enum logic {
        FLG_CLEAR = 1'b0,
        FLG_SET   = 1'b1
    } flag_state_t;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    function automatic int flag_bit(input int idx);
        case (idx)
            FLG_DET_PARITY: flag_bit = 15;
            FLG_SIG_SERR:   flag_bit = 14;
            FLG_RCV_MABORT: flag_bit = 13;
            FLG_RCV_TABORT: flag_bit = 12;
            FLG_SIG_TABORT: flag_bit = 11;
            default:        flag_bit = 8;
        endcase
    endfunction

endpackage

// File: rtl/pcists_event_qual.sv
module pcists_event_qual
    import pcists_pkg::*;
(
    input  logic      ev_addr_parity,
    input  logic      ev_data_parity,
    input  logic      ev_serr,
    input  logic      ev_master_abort,
    input  logic      ev_special_cycle,
    input  logic      ev_ta_received,
    input  logic      ev_ta_signaled,
    input  logic      perr_resp_en,
    input  logic      is_master,
    output flag_vec_t set_vec
);

    always_comb begin
        set_vec = '0;
        // Detection ignores both the response enable and the role.
        set_vec[FLG_DET_PARITY] = ev_addr_parity | ev_data_parity;
        set_vec[FLG_SIG_SERR]   = ev_serr;
        set_vec[FLG_RCV_MABORT] = ev_master_abort & is_master & ~ev_special_cycle;
        set_vec[FLG_RCV_TABORT] = ev_ta_received & is_master;
        set_vec[FLG_SIG_TABORT] = ev_ta_signaled & ~is_master;
        set_vec[FLG_MST_PARITY] = ev_data_parity & is_master & perr_resp_en;
    end

endmodule

// File: rtl/pcists_sticky_flag.sv
module pcists_sticky_flag
    import pcists_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_state_t state_q, state_d;

    // Next state: CLR_TO_SET on an event, SET_TO_CLR on a clear with no event.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: if (set_i) state_d = FLG_SET;
            FLG_SET:   if (clr_i && !set_i) state_d = FLG_CLEAR;
            default:   state_d = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FLG_SET: flag_o = 1'b1;
            default: flag_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcists_read_mux.sv
module pcists_read_mux
    import pcists_pkg::*;
(
    input  flag_vec_t             flags,
    input  logic                  irq_pending,
    output logic [STATUS_W-1:0]   rd_data
);

    always_comb begin
        rd_data          = FIXED_ONES;
        rd_data[BIT_IRQ] = irq_pending;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            rd_data[flag_bit(i)] = flags[i];
        end
    end

endmodule

// File: rtl/pcists_status_reg.sv
module pcists_status_reg
    import pcists_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [STATUS_W-1:0]   wr_data,
    input  logic [NUM_LANES-1:0]  wr_be,
    input  logic                  ev_addr_parity,
    input  logic                  ev_data_parity,
    input  logic                  ev_serr,
    input  logic                  ev_master_abort,
    input  logic                  ev_special_cycle,
    input  logic                  ev_ta_received,
    input  logic                  ev_ta_signaled,
    input  logic                  perr_resp_en,
    input  logic                  is_master,
    input  logic                  irq_pending,
    output logic [STATUS_W-1:0]   rd_data
);

    flag_vec_t             set_vec;
    flag_vec_t             clr_vec;
    flag_vec_t             flags;
    logic [STATUS_W-1:0]   clr_mask;

    // Per-lane write-one mask.
    always_comb begin
        for (int b = 0; b < STATUS_W; b++) begin
            clr_mask[b] = wr_en & wr_be[b / LANE_W] & wr_data[b];
        end
    end

    pcists_event_qual u_qual (
        .ev_addr_parity   (ev_addr_parity),
        .ev_data_parity   (ev_data_parity),
        .ev_serr          (ev_serr),
        .ev_master_abort  (ev_master_abort),
        .ev_special_cycle (ev_special_cycle),
        .ev_ta_received   (ev_ta_received),
        .ev_ta_signaled   (ev_ta_signaled),
        .perr_resp_en     (perr_resp_en),
        .is_master        (is_master),
        .set_vec          (set_vec)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        assign clr_vec[g] = clr_mask[flag_bit(g)];
        pcists_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[g]),
            .clr_i  (clr_vec[g]),
            .flag_o (flags[g])
        );
    end

    pcists_read_mux u_rd (
        .flags       (flags),
        .irq_pending (irq_pending),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/pcists_status_chk.sv
module pcists_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [1:0]  wr_be,
    input logic        ev_addr_parity,
    input logic        ev_data_parity,
    input logic        ev_serr,
    input logic        ev_master_abort,
    input logic        ev_special_cycle,
    input logic        ev_ta_received,
    input logic        ev_ta_signaled,
    input logic        perr_resp_en,
    input logic        is_master,
    input logic        irq_pending,
    input logic [15:0] rd_data
);

    logic any_ev;
    logic hi_wr;
    assign any_ev = ev_addr_parity | ev_data_parity | ev_serr | ev_master_abort |
                    ev_ta_received | ev_ta_signaled;
    assign hi_wr  = wr_en & wr_be[1];

    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[10:9] == 2'b00) && (rd_data[6] == 1'b0) && (rd_data[2:0] == 3'b000) &&
        rd_data[7] && rd_data[5] && rd_data[4]);

    a_r3_irq_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] == irq_pending);

    a_r5_serr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_serr |=> rd_data[14]);

    a_r6_special_cycle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_master_abort && ev_special_cycle && !rd_data[13]) |=> !rd_data[13]);

    a_r8_wrong_role: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ta_signaled && is_master && !rd_data[11]) |=> !rd_data[11]);

    a_r11_lane_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_wr && !any_ev) |=> (rd_data[15:11] == $past(rd_data[15:11])) &&
                                (rd_data[8] == $past(rd_data[8])));

    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_addr_parity && hi_wr && wr_data[15]) |=> rd_data[15]);

    a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[14] && !(hi_wr && wr_data[14])) |=> rd_data[14]);

endmodule

bind pcists_status_reg pcists_status_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en            (wr_en),
    .wr_data          (wr_data),
    .wr_be            (wr_be),
    .ev_addr_parity   (ev_addr_parity),
    .ev_data_parity   (ev_data_parity),
    .ev_serr          (ev_serr),
    .ev_master_abort  (ev_master_abort),
    .ev_special_cycle (ev_special_cycle),
    .ev_ta_received   (ev_ta_received),
    .ev_ta_signaled   (ev_ta_signaled),
    .perr_resp_en     (perr_resp_en),
    .is_master        (is_master),
    .irq_pending      (irq_pending),
    .rd_data          (rd_data)
);

// File: tb/test_pcists_status_reg.sv
module test_pcists_status_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_be = '0;
    logic        ev_addr_parity = 1'b0, ev_data_parity = 1'b0, ev_serr = 1'b0;
    logic        ev_master_abort = 1'b0, ev_special_cycle = 1'b0;
    logic        ev_ta_received = 1'b0, ev_ta_signaled = 1'b0;
    logic        perr_resp_en = 1'b0, is_master = 1'b0, irq_pending = 1'b0;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pcists_status_reg i_pcists_status_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
        .ev_addr_parity(ev_addr_parity), .ev_data_parity(ev_data_parity),
        .ev_serr(ev_serr), .ev_master_abort(ev_master_abort),
        .ev_special_cycle(ev_special_cycle), .ev_ta_received(ev_ta_received),
        .ev_ta_signaled(ev_ta_signaled), .perr_resp_en(perr_resp_en),
        .is_master(is_master), .irq_pending(irq_pending), .rd_data(rd_data)
    );

    localparam logic [15:0] BASE = 16'h00B0;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_data = '0; wr_be = '0;
        ev_addr_parity = 0; ev_data_parity = 0; ev_serr = 0; ev_master_abort = 0;
        ev_special_cycle = 0; ev_ta_received = 0; ev_ta_signaled = 0;
    endtask

    // Inputs already driven; let one edge pass, drop pulses, sample at negedge.
    task automatic step();
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic write(input logic [15:0] d, input logic [1:0] be);
        wr_en = 1; wr_data = d; wr_be = be;
        step();
    endtask

    task automatic clear_all();
        write(16'hFFFF, 2'b11);
    endtask

    task automatic t_reset();
        check("R1 reset value", rd_data, BASE);
    endtask

    task automatic t_irq();
        irq_pending = 1; #1;
        check("R3 irq high", rd_data, BASE | 16'h0008);
        irq_pending = 0; #1;
        check("R3 irq low", rd_data, BASE);
    endtask

    task automatic t_parity();
        clear_all();
        perr_resp_en = 0; is_master = 0; ev_addr_parity = 1; step();
        check("R4 address parity, enable off", rd_data, BASE | 16'h8000);
        clear_all();
        perr_resp_en = 0; is_master = 1; ev_data_parity = 1; step();
        check("R4 data parity as master, enable off", rd_data, BASE | 16'h8000);
    endtask

    task automatic t_serr();
        clear_all();
        ev_serr = 1; step();
        check("R5 system error", rd_data, BASE | 16'h4000);
        repeat (3) step();
        check("R13 flag held", rd_data, BASE | 16'h4000);
    endtask

    task automatic t_master_abort();
        clear_all();
        is_master = 1; ev_master_abort = 1; ev_special_cycle = 1; step();
        check("R6 special cycle ignored", rd_data, BASE);
        is_master = 1; ev_master_abort = 1; step();
        check("R6 master abort", rd_data, BASE | 16'h2000);
    endtask

    task automatic t_target_aborts();
        clear_all();
        is_master = 0; ev_ta_received = 1; step();
        check("R7 received abort as target ignored", rd_data, BASE);
        is_master = 1; ev_ta_received = 1; step();
        check("R7 received abort as master", rd_data, BASE | 16'h1000);
        clear_all();
        is_master = 1; ev_ta_signaled = 1; step();
        check("R8 signalled abort as master ignored", rd_data, BASE);
        is_master = 0; ev_ta_signaled = 1; step();
        check("R8 signalled abort as target", rd_data, BASE | 16'h0800);
    endtask

    task automatic t_master_parity();
        for (int k = 0; k < 4; k++) begin
            clear_all();
            is_master = k[0]; perr_resp_en = k[1]; ev_data_parity = 1; step();
            check("R9 master data parity qualify", rd_data,
                  BASE | 16'h8000 | ((k == 3) ? 16'h0100 : 16'h0000));
        end
        perr_resp_en = 0;
    endtask

    task automatic t_w1c();
        clear_all();
        is_master = 1; perr_resp_en = 1;
        ev_serr = 1; ev_data_parity = 1; ev_master_abort = 1; step();
        check("R10 setup", rd_data, BASE | 16'hE100);
        write(16'h2100, 2'b10);
        check("R10 partial clear", rd_data, BASE | 16'hC000);
        write(16'h00FF, 2'b11);
        check("R10 zeros keep flags", rd_data, BASE | 16'hC000);
        write(16'hFFFF, 2'b01);
        check("R11 low lane only", rd_data, BASE | 16'hC000);
        write(16'hFFFF, 2'b00);
        check("R11 no lane", rd_data, BASE | 16'hC000);
        clear_all();
        check("R10 clear all", rd_data, BASE);
        perr_resp_en = 0;
    endtask

    task automatic t_set_wins();
        clear_all();
        ev_serr = 1; step();
        ev_serr = 1; wr_en = 1; wr_data = 16'h4000; wr_be = 2'b10; step();
        check("R12 set beats clear on set flag", rd_data, BASE | 16'h4000);
        clear_all();
        ev_addr_parity = 1; wr_en = 1; wr_data = 16'hFFFF; wr_be = 2'b11; step();
        check("R12 set beats clear on clear flag", rd_data, BASE | 16'h8000);
        clear_all();
    endtask

    task automatic t_fixed_bits();
        ev_serr = 1; ev_addr_parity = 1; wr_en = 1; wr_data = 16'h06FF; wr_be = 2'b11; step();
        check("R2 fixed bits", rd_data & 16'h06F7, 16'h00B0);
        clear_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_irq();
        t_parity();
        t_serr();
        t_master_abort();
        t_target_aborts();
        t_master_parity();
        t_w1c();
        t_set_wins();
        t_fixed_bits();
        finish_run();
    end

endmodule